// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is a serial peripheral interface host that software drives through six word-aligned 32-bit registers. Software first picks the clock polarity, the clock phase and a two-stage divider for the serial clock. It then lowers chip select by writing a register bit. Each byte written to the transmit register runs one 8-bit full-duplex exchange with the attached device, and the byte received in that exchange is read back from the receive register.

The serial clock comes from the system clock in two stages. A coarse prescaler divides by 16 or by 128, and a 5-bit field then sets a further even division. The host shifts the most significant bit first. Two flags report progress: a busy flag, set while a byte is pending or shifting, and a receive-full flag, set when a completed byte is waiting in the receive register. Chip select has no automatic sequencing. It always follows a bit in the system control register.

Top module: `spi_host_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except system control, which reads 0x40. `csn_o` is 1, and `sclk_o` and `mosi_o` are 0.
- R2: Registers are decoded from address bits [4:2], and bits [1:0] are ignored. The map is: 0x00 mode (bit 7 phase, bit 6 polarity, bit 5 coarse select, bits [4:0] fine divider), 0x04 status (bit 0 busy, bit 2 receive-full), 0x08 system control, 0x0C transmit, 0x10 receive, 0x14 auxiliary control. The mode, system, transmit, receive and auxiliary registers each hold 8 bits and read back zero-extended. Offsets 0x18 and 0x1C read 0 and ignore writes.
- R3: `csn_o` always equals bit 6 of system control. Writing 1 there releases the line (high) and writing 0 asserts it (low).
- R4: A write to the transmit register starts a transfer of `reg_wdata[7:0]` only when system control bit 0 (host enable) is 1 and busy is 0. Busy reads 1 from the next cycle until the transfer ends. With host enable at 0, the write is ignored and the transmit register keeps its value.
- R5: A write to the transmit register while busy is 1 is ignored. It changes neither the byte being shifted nor the transmit readback.
- R6: Each half period of the serial clock lasts H = P×(fine+1) system cycles, where P = 16 when the coarse bit is 0 and P = 128 when it is 1. A transfer keeps busy at 1 for exactly 16×H cycles, and `sclk_o` toggles 16 times.
- R7: While idle, `sclk_o` rests at the polarity bit. It is back at that level when the transfer ends.
- R8: Data moves MSB first, one bit out and one bit in per clock period. With phase 0, the first bit is on `mosi_o` before the first clock edge, `miso_i` is sampled on leading edges, and the next bit is driven on trailing edges. With phase 1, bits are driven on leading edges and sampled on trailing edges.
- R9: At the end of a transfer, the receive register takes the received byte and receive-full goes to 1 on the same clock edge on which busy falls.
- R10: A read of the receive register (`reg_re` at 0x10) clears receive-full. If a transfer completes in the same cycle, the completion wins.
- R11: Any write to the status register clears receive-full and leaves busy and the received data unchanged. If a transfer completes in the same cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_re | input | 1 | Register read strobe; a read of the receive register has a side effect |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data from host to device |
| miso_i | input | 1 | Serial data from device to host |
| csn_o | output | 1 | Chip select, active low |

## Verification
The assertions assume that the mode register is not rewritten while busy is 1. The idle-level and sampling properties compare `sclk_o` against the polarity bit that was in force when the transfer started. They also assume that `reg_re` and `reg_we` are low during reset. The stimulus honours both assumptions: every mode write happens while the block is idle, followed by one settling cycle, and the bus strobes stay low until reset is released. The only write made during a transfer targets the transmit register, which is the case R5 checks.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int REG_W   = 8;
    localparam int FINE_W  = 5;
    localparam int N_REGS  = 6;

    // register index = byte offset / 4
    typedef enum logic [2:0] {
        RG_MODE = 3'd0,
        RG_STAT = 3'd1,
        RG_SYS  = 3'd2,
        RG_TX   = 3'd3,
        RG_RX   = 3'd4,
        RG_AUX  = 3'd5
    } reg_sel_e;

    // status bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_RXF  = 2;

    // system control bit positions and reset value
    localparam int SYS_HOST_EN = 0;
    localparam int SYS_CS_LVL  = 6;
    localparam logic [REG_W-1:0] SYS_RESET = 8'h40;

    // mode register layout, MSB first
    typedef struct packed {
        logic              phase;
        logic              pol;
        logic              coarse;
        logic [FINE_W-1:0] fine;
    } mode_t;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output mode_t             mode_o,
    output logic              csn_o,
    output logic              rx_full_o,
    output logic              start_o,
    output logic [DATA_W-1:0] tx_byte_o
);

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [REG_W-1:0]  mode;
        logic [REG_W-1:0]  sys;
        logic [REG_W-1:0]  aux;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              rxf;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        mode: '0, sys: SYS_RESET, aux: '0, tx: '0, rx: '0, rxf: 1'b0
    };

    regs_t q, d;

    logic [IDX_W-1:0] idx;
    logic             hit;
    reg_sel_e         sel;
    logic             unused_bits;

    assign idx         = addr[ADDR_W-1:2];
    assign hit         = (idx < IDX_W'(N_REGS));
    assign sel         = reg_sel_e'(idx[2:0]);
    assign unused_bits = ^{addr[1:0], wdata[31:DATA_W]};

    always_comb begin
        d       = q;
        start_o = 1'b0;
        if (we && hit) begin
            case (sel)
                RG_MODE: d.mode = wdata[REG_W-1:0];
                RG_STAT: d.rxf  = 1'b0;
                RG_SYS:  d.sys  = wdata[REG_W-1:0];
                RG_TX: begin
                    if (!busy && q.sys[SYS_HOST_EN]) begin
                        start_o = 1'b1;
                        d.tx    = wdata[DATA_W-1:0];
                    end
                end
                RG_AUX:  d.aux  = wdata[REG_W-1:0];
                default: ;
            endcase
        end
        if (re && hit && sel == RG_RX) begin
            d.rxf = 1'b0;
        end
        // completion overrides any clear in the same cycle
        if (done) begin
            d.rx  = rx_byte;
            d.rxf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= REGS_RESET;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                RG_MODE: rdata = 32'(q.mode);
                RG_STAT: begin
                    rdata[STAT_BUSY] = busy;
                    rdata[STAT_RXF]  = q.rxf;
                end
                RG_SYS:  rdata = 32'(q.sys);
                RG_TX:   rdata = 32'(q.tx);
                RG_RX:   rdata = 32'(q.rx);
                RG_AUX:  rdata = 32'(q.aux);
                default: rdata = '0;
            endcase
        end
    end

    assign mode_o    = mode_t'(q.mode);
    assign csn_o     = q.sys[SYS_CS_LVL];
    assign rx_full_o = q.rxf;
    assign tx_byte_o = wdata[DATA_W-1:0];

endmodule

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int FINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              coarse,
    input  logic [FINE_W-1:0] fine,
    output logic              edge_o
);

    localparam int PRE_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
    localparam int PRE_W   = $clog2(PRE_MAX);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [FINE_W-1:0] cnt;
    } div_t;

    div_t q, d;
    logic [PRE_W-1:0] pre_lim;

    assign pre_lim = coarse ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);

    always_comb begin
        d      = q;
        edge_o = 1'b0;
        if (!run) begin
            d = '0;
        end else if (q.pre == pre_lim) begin
            d.pre = '0;
            if (q.cnt == fine) begin
                d.cnt  = '0;
                edge_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              edge_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_byte_o
);

    localparam int EDGES = 2 * DATA_W;
    localparam int CNT_W = $clog2(EDGES);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic              sclk;
        logic              mosi;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (!q.busy) begin
            d.sclk = cpol;
            if (start) begin
                d.busy  = 1'b1;
                d.phase = cpha;
                d.sh    = tx_byte;
                d.mosi  = tx_byte[DATA_W-1];
                d.cnt   = '0;
            end
        end else if (edge_i) begin
            d.sclk = ~q.sclk;
            d.cnt  = q.cnt + 1'b1;
            // even count = leading edge; phase 0 samples there, phase 1 on trailing
            if (q.cnt[0] == q.phase) begin
                d.sh = {q.sh[DATA_W-2:0], miso_i};
            end else begin
                d.mosi = q.sh[DATA_W-1];
            end
            if (q.cnt == CNT_W'(EDGES - 1)) begin
                d.busy = 1'b0;
                done_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = q.busy;
    assign sclk_o    = q.sclk;
    assign mosi_o    = q.mosi;
    assign rx_byte_o = d.sh;

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              csn_o
);

    mode_t             mode;
    logic              eng_busy;
    logic              eng_done;
    logic              edge_tick;
    logic              start;
    logic              rx_full;
    logic              mode_pol;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;

    assign mode_pol = mode.pol;

    spi_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .re        (reg_re),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (rx_byte),
        .mode_o    (mode),
        .csn_o     (csn_o),
        .rx_full_o (rx_full),
        .start_o   (start),
        .tx_byte_o (tx_byte)
    );

    spi_host_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .FINE_W(FINE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (eng_busy),
        .coarse (mode.coarse),
        .fine   (mode.fine),
        .edge_o (edge_tick)
    );

    spi_host_shifter #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_byte   (tx_byte),
        .cpol      (mode.pol),
        .cpha      (mode.phase),
        .edge_i    (edge_tick),
        .miso_i    (miso_i),
        .busy_o    (eng_busy),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .done_o    (eng_done),
        .rx_byte_o (rx_byte)
    );

endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              csn_o,
    input logic              sclk_o,
    input logic              busy,
    input logic              rx_full,
    input logic              pol
);

    localparam int IDX_W = ADDR_W - 2;

    logic sel_stat, sel_sys, sel_tx, sel_rx;
    assign sel_stat = (reg_addr[ADDR_W-1:2] == IDX_W'(1));
    assign sel_sys  = (reg_addr[ADDR_W-1:2] == IDX_W'(2));
    assign sel_tx   = (reg_addr[ADDR_W-1:2] == IDX_W'(3));
    assign sel_rx   = (reg_addr[ADDR_W-1:2] == IDX_W'(4));

    p_cs_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csn_o) |-> $past(reg_we && sel_sys));

    p_start_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && sel_tx));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o == $past(pol));

    p_done_sets_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_full);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_re && sel_rx) && !$fell(busy) |-> !rx_full);

    p_stat_write_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we && sel_stat) && !$fell(busy) |-> !rx_full);

endmodule

bind spi_host_ctrl spi_host_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .csn_o    (csn_o),
    .sclk_o   (sclk_o),
    .busy     (eng_busy),
    .rx_full  (rx_full),
    .pol      (mode_pol)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;

    localparam logic [4:0] A_MODE = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_SYS  = 5'h08;
    localparam logic [4:0] A_TX   = 5'h0C;
    localparam logic [4:0] A_RX   = 5'h10;
    localparam logic [4:0] A_AUX  = 5'h14;

    // {mode, tx byte, device byte}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        24'h00_A5_3C, 24'h40_5A_C3, 24'h80_F0_0F, 24'hC0_81_7E,
        24'h01_96_69, 24'hC3_00_FF, 24'h20_FF_00, 24'h62_3B_D4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk_o, mosi_o, csn_o;
    logic        miso_i = 1'b0;

    int total = 0;
    int bad = 0;

    // device model state
    logic       slv_on = 1'b0;
    logic       slv_cpha = 1'b0;
    logic [7:0] slv_tx = '0;
    logic [7:0] slv_rx = '0;
    int         slv_n = 0;
    int         slv_bi = 0;

    always #10 clk = ~clk;

    spi_host_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .miso_i    (miso_i),
        .csn_o     (csn_o)
    );

    always @(sclk_o) begin
        if (slv_on) begin
            slv_n = slv_n + 1;
            if ((slv_n % 2 == 1) ^ slv_cpha) begin
                slv_rx = {slv_rx[6:0], mosi_o};
            end else if (!(slv_cpha && slv_n == 1)) begin
                slv_bi = slv_bi + 1;
            end
            miso_i = (slv_bi < 8) ? slv_tx[7 - slv_bi] : 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle(output int dur);
        dur = 0;
        reg_addr = A_STAT;
        while (1) begin
            #1;
            if (reg_rdata[0]) dur++;
            else break;
            @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] mode, input logic [7:0] tx,
                        input logic [7:0] dev, output int dur);
        wr(A_MODE, {24'h0, mode});
        wr(A_SYS, 32'h21);
        @(negedge clk);
        slv_tx = dev; slv_rx = '0; slv_n = 0; slv_bi = 0;
        slv_cpha = mode[7]; miso_i = dev[7]; slv_on = 1'b1;
        wr(A_TX, {24'h0, tx});
        wait_idle(dur);
        slv_on = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int dur;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 csn", {31'h0, csn_o}, 32'h1);
        chk("R1 sclk", {31'h0, sclk_o}, 32'h0);
        chk("R1 mosi", {31'h0, mosi_o}, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_SYS, v);  chk("R1 sysctl", v, 32'h40);
        rd(A_MODE, v); chk("R1 mode", v, 32'h0);
        rd(A_RX, v);   chk("R1 rx", v, 32'h0);

        // R4 host disabled: write ignored
        wr(A_TX, 32'h77);
        #1 reg_addr = A_STAT; #1 chk("R4 no start while disabled", reg_rdata, 32'h0);
        rd(A_TX, v); chk("R4 tx not loaded while disabled", v, 32'h0);

        // R2 map, width and decode
        wr(A_AUX, 32'hFFFF_FF9C);
        rd(A_AUX, v); chk("R2 aux readback", v, 32'h9C);
        rd(5'h15, v); chk("R2 low addr bits ignored", v, 32'h9C);
        rd(5'h18, v); chk("R2 unmapped reads zero", v, 32'h0);
        wr(5'h1C, 32'hFF);
        rd(A_AUX, v); chk("R2 unmapped write ignored", v, 32'h9C);

        // R3 chip select follows bit 6
        wr(A_SYS, 32'h61); chk("R3 cs released", {31'h0, csn_o}, 32'h1);
        wr(A_SYS, 32'h21); chk("R3 cs asserted", {31'h0, csn_o}, 32'h0);

        // vector table: R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [7:0] m, t, s;
            int h;
            m = VEC[i][23:16]; t = VEC[i][15:8]; s = VEC[i][7:0];
            h = (m[5] ? 128 : 16) * (int'(m[4:0]) + 1);
            xfer(m, t, s, dur);
            chk("R6 busy duration", dur, 16 * h);
            chk("R7 sclk back at polarity", {31'h0, sclk_o}, {31'h0, m[6]});
            chk("R8 device received tx byte", {24'h0, slv_rx}, {24'h0, t});
            rd(A_STAT, v); chk("R9 receive-full set", v, 32'h4);
            rd(A_RX, v);   chk("R8 received byte", v, {24'h0, s});
            rd(A_STAT, v); chk("R10 read clears receive-full", v, 32'h0);
        end

        // R4 busy visible, R5 write during transfer ignored
        wr(A_MODE, 32'h00);
        @(negedge clk);
        slv_tx = 8'h5C; slv_rx = '0; slv_n = 0; slv_bi = 0;
        slv_cpha = 1'b0; miso_i = 1'b0; slv_on = 1'b1;
        wr(A_TX, 32'hFFFF_FFA5);
        #1 reg_addr = A_STAT; #1 chk("R4 busy after start", reg_rdata, 32'h1);
        repeat (40) @(negedge clk);
        wr(A_TX, 32'h11);
        wait_idle(dur);
        slv_on = 1'b0;
        chk("R5 shifted byte unchanged", {24'h0, slv_rx}, 32'hA5);
        rd(A_TX, v); chk("R5 tx readback unchanged", v, 32'hA5);

        // R11 status write clears receive-full only
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R11 status write clears flag", v, 32'h0);
        rd(A_RX, v);   chk("R11 data kept", v, 32'h5C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule